// File: doc/BRIEF.md
# Preemptible Address/Data Join Write Controller

The controller gathers one address and one data word, each arriving as a valid-qualified bus event. The two events may come in either order or in the same cycle. Once it has both, it raises a single write strobe for one cycle. The strobe carries the captured address and data. The controller then stays busy for a programmable number of cycles while the write completes, and afterwards returns to collecting the next pair.

An active-high restart input preempts every phase: a partial collection, the strobe cycle and the latency countdown. After a restart the controller begins a fresh collection with nothing captured. The controller is meant to sit between two independent producers and a write port whose completion time is known in advance.

Top module: `join_write_ctrl`

## Requirements
- R1: A strobe is raised only after both an address event (`addr_vld`=1) and a data event (`data_vld`=1) have been accepted. The two events may arrive in either order, separated by any number of cycles.
- R2: Each accepted pair produces exactly one strobe cycle. During that cycle `wr_addr` and `wr_data` show the first address and the first data accepted since collection began. Repeated events of a kind already captured are ignored.
- R3: If both events are valid in the same collecting cycle, `wr_stb` is high in the next cycle.
- R4: `busy` is high in the strobe cycle. It stays high for `lat_cnt` further cycles, with `lat_cnt` sampled in the strobe cycle. Collecting then resumes and `busy` is low.
- R5: When `lat_cnt` is 0 in the strobe cycle, `busy` is low in the next cycle and events are accepted again.
- R6: Address and data events presented while `busy` is high are ignored and never contribute to a later strobe.
- R7: `restart`=1 during collection discards any partly captured pair. Events presented in the same cycle as the restart are ignored.
- R8: `restart`=1 in any cycle makes `busy` low in the next cycle. This includes the middle of the latency countdown.
- R9: `restart`=1 in the strobe cycle holds `wr_stb` low in that cycle, and the pair is dropped.
- R10: While `rst_n` is low and after its release, `busy` and `wr_stb` are low and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_vld | input | 1 | Address event present |
| addr_in | input | AW | Address value |
| data_vld | input | 1 | Data event present |
| data_in | input | DW | Data value |
| lat_cnt | input | LW | Write latency in cycles, sampled in the strobe cycle |
| restart | input | 1 | Preempting restart, active high |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | AW | Captured address, valid with `wr_stb` |
| wr_data | output | DW | Captured data, valid with `wr_stb` |
| busy | output | 1 | Strobe or latency wait in progress |

## Verification
The join is tried three ways: address first, data first, and both in one cycle. These runs separate a controller that truly waits for both events from one that assumes a fixed order, and they expose an off-by-one in the strobe cycle. Repeated addresses before the data arrives show whether the first or the latest value is kept. Events injected during the wait show whether the wait really blocks capture. Restarts placed in collection, in the strobe cycle and mid-countdown, together with latencies of 0, 1 and larger, show which phases are truly preemptible and where the countdown ends.

// File: rtl/join_write_pkg.sv
// Shared types for the address/data join write controller.
// Assumes: no other block defines these names.
package join_write_pkg;
    // Controller phase.
    typedef enum logic [1:0] {
        PH_COLLECT = 2'd0,
        PH_STROBE  = 2'd1,
        PH_WAIT    = 2'd2
    } jw_phase_e;
endpackage

// File: rtl/jw_capture.sv
// Holds the address and data halves of a pair with a captured flag each.
// The first event of each kind is kept; repeats are ignored until clear.
// Assumes: clr has priority over capture; en is low outside collection.
module jw_capture #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          clr,
    input  logic          addr_vld,
    input  logic [AW-1:0] addr_in,
    input  logic          data_vld,
    input  logic [DW-1:0] data_in,
    output logic          have_addr,
    output logic          have_data,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic          pair_done
);
    logic take_addr, take_data;

    // Decide which halves are accepted this cycle.
    always_comb begin
        take_addr = en && addr_vld && !have_addr;
        take_data = en && data_vld && !have_data;
        pair_done = en && (have_addr || addr_vld) && (have_data || data_vld);
    end

    // Capture flags and values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_addr <= 1'b0;
            have_data <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
        end else if (clr) begin
            have_addr <= 1'b0;
            have_data <= 1'b0;
        end else begin
            if (take_addr) begin
                have_addr <= 1'b1;
                addr_q    <= addr_in;
            end
            if (take_data) begin
                have_data <= 1'b1;
                data_q    <= data_in;
            end
        end
    end
endmodule

// File: rtl/jw_latency_timer.sv
// Down-counter for the write latency wait; expire is high in the last wait cycle.
// Assumes: load is raised only with a nonzero load_val; abort wins over load.
module jw_latency_timer #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          abort,
    input  logic [LW-1:0] load_val,
    output logic          expire
);
    localparam logic [LW-1:0] ONE = LW'(1);
    logic [LW-1:0] cnt_q;

    // Load, count down or abort the remaining wait.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (abort)           cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - ONE;
    end

    // Final wait cycle indicator.
    always_comb expire = (cnt_q == ONE);
endmodule

// File: rtl/join_write_ctrl.sv
// Top of the address/data join write controller: collect both halves in any
// order, strobe once, wait lat_cnt cycles, loop; restart preempts every phase.
// Assumes: restart is synchronous to clk; lat_cnt is stable in the strobe cycle.
module join_write_ctrl
    import join_write_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_vld,
    input  logic [AW-1:0] addr_in,
    input  logic          data_vld,
    input  logic [DW-1:0] data_in,
    input  logic [LW-1:0] lat_cnt,
    input  logic          restart,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          busy
);
    jw_phase_e phase_q, phase_d;
    logic      cap_en, cap_clr, pair_done, have_addr, have_data;
    logic      tmr_load, tmr_expire, lat_zero;

    // Capture control derived from phase and restart.
    always_comb begin
        cap_en   = (phase_q == PH_COLLECT) && !restart;
        cap_clr  = restart || (phase_q == PH_STROBE);
        lat_zero = (lat_cnt == '0);
        tmr_load = (phase_q == PH_STROBE) && !restart && !lat_zero;
    end

    jw_capture #(.AW(AW), .DW(DW)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cap_en),
        .clr       (cap_clr),
        .addr_vld  (addr_vld),
        .addr_in   (addr_in),
        .data_vld  (data_vld),
        .data_in   (data_in),
        .have_addr (have_addr),
        .have_data (have_data),
        .addr_q    (wr_addr),
        .data_q    (wr_data),
        .pair_done (pair_done)
    );

    jw_latency_timer #(.LW(LW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .abort    (restart),
        .load_val (lat_cnt),
        .expire   (tmr_expire)
    );

    // Next phase, with restart preempting every phase.
    always_comb begin
        phase_d = phase_q;
        if (restart) begin
            phase_d = PH_COLLECT;
        end else begin
            unique case (phase_q)
                PH_COLLECT: if (pair_done) phase_d = PH_STROBE;
                PH_STROBE:  phase_d = lat_zero ? PH_COLLECT : PH_WAIT;
                PH_WAIT:    if (tmr_expire) phase_d = PH_COLLECT;
                default:    phase_d = PH_COLLECT;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_COLLECT;
        else        phase_q <= phase_d;
    end

    // Outputs: strobe suppressed by a coincident restart.
    always_comb begin
        wr_stb = (phase_q == PH_STROBE) && !restart;
        busy   = (phase_q != PH_COLLECT);
    end
endmodule

// File: rtl/join_write_chk.sv
// Assertion checker for join_write_ctrl, attached by bind below.
// Assumes: connected to the top's ports and capture flags.
module join_write_chk #(
    parameter int LW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_vld,
    input logic          data_vld,
    input logic [LW-1:0] lat_cnt,
    input logic          restart,
    input logic          wr_stb,
    input logic          busy,
    input logic          in_wait,
    input logic          have_addr,
    input logic          have_data
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R2
    AST_SAME_CYCLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && addr_vld && data_vld && !restart) |=> (wr_stb || restart)); // R3
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> busy); // R4
    AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && lat_cnt != '0) |=> busy); // R4
    AST_LAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && lat_cnt == '0) |=> !busy); // R5
    AST_WAIT_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> (!have_addr && !have_data)); // R6
    AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !busy); // R8
    AST_RESTART_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !wr_stb); // R9
endmodule

bind join_write_ctrl join_write_chk #(.LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_vld  (addr_vld),
    .data_vld  (data_vld),
    .lat_cnt   (lat_cnt),
    .restart   (restart),
    .wr_stb    (wr_stb),
    .busy      (busy),
    .in_wait   (phase_q == join_write_pkg::PH_WAIT),
    .have_addr (have_addr),
    .have_data (have_data)
);

// File: tb/tb_join_write_ctrl.sv
module tb_join_write_ctrl;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_vld = 1'b0, data_vld = 1'b0, restart = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic [LW-1:0] lat_cnt = '0;
    logic          wr_stb, busy;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0, fails = 0;

    // Reference model state
    int     m_phase = 0;   // 0 collect, 1 strobe, 2 wait
    int     m_rem = 0;
    bit     m_ha = 0, m_hd = 0;
    longint m_a = 0, m_d = 0;
    int     m_strobes = 0, d_strobes = 0;

    join_write_ctrl #(.AW(AW), .DW(DW), .LW(LW)) dut (
        .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_in(addr_in),
        .data_vld(data_vld), .data_in(data_in), .lat_cnt(lat_cnt),
        .restart(restart), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy));

    always #10 clk = ~clk;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // One cycle: drive inputs, compare outputs with the model, advance the model.
    task automatic cyc(input string tag, input bit av, input longint a, input bit dv,
                       input longint d, input int lat, input bit rs);
        bit exp_stb;
        @(negedge clk);
        addr_vld = av; addr_in = AW'(a); data_vld = dv; data_in = DW'(d);
        lat_cnt = LW'(lat); restart = rs;
        #1;
        exp_stb = (m_phase == 1) && !rs;
        check(tag, "busy", busy, m_phase != 0);
        check(tag, "wr_stb", wr_stb, exp_stb);
        if (exp_stb) begin
            m_strobes++;
            check(tag, "wr_addr", wr_addr, m_a);
            check(tag, "wr_data", wr_data, m_d);
        end
        if (wr_stb) d_strobes++;
        case (m_phase)
            0: if (rs) begin m_ha = 0; m_hd = 0; end
               else begin
                   if (av && !m_ha) begin m_ha = 1; m_a = a; end
                   if (dv && !m_hd) begin m_hd = 1; m_d = d; end
                   if (m_ha && m_hd) m_phase = 1;
               end
            1: begin
                   m_ha = 0; m_hd = 0;
                   if (rs || lat == 0) m_phase = 0;
                   else begin m_phase = 2; m_rem = lat; end
               end
            default: if (rs || m_rem == 1) m_phase = 0; else m_rem--;
        endcase
    endtask

    task automatic idle(input string tag, input int n, input int lat);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, lat, 0);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        #1;
        check("R10", "busy in reset", busy, 0);
        check("R10", "wr_stb in reset", wr_stb, 0);
        @(negedge clk); rst_n = 1'b1;
        idle("R10", 2, 0);

        // R1: address first, data later; R4 latency 3
        cyc("R1", 1, 'h1111, 0, 0, 3, 0);
        idle("R1", 2, 3);
        cyc("R1", 0, 0, 1, 'hAAAA0001, 3, 0);
        cyc("R4", 0, 0, 0, 0, 3, 0);       // strobe cycle
        idle("R4", 5, 3);

        // R1: data first, address later, with repeated data (R2 first kept)
        cyc("R1", 0, 0, 1, 'hBBBB0002, 2, 0);
        cyc("R2", 0, 0, 1, 'hDEAD0000, 2, 0);
        cyc("R1", 1, 'h2222, 0, 0, 2, 0);
        cyc("R2", 1, 'h9999, 1, 'hFFFF, 2, 0); // strobe cycle, events ignored (R6)
        cyc("R6", 1, 'h7777, 1, 'h7777, 2, 0);
        cyc("R6", 1, 'h7777, 0, 0, 2, 0);
        idle("R6", 3, 2);

        // R3 + R5: same-cycle pair, zero latency, back-to-back
        cyc("R3", 1, 'h3333, 1, 'hC0000003, 0, 0);
        cyc("R5", 1, 'h4444, 1, 'hC0000004, 0, 0);  // strobe; events ignored
        cyc("R5", 1, 'h5555, 1, 'hC0000005, 0, 0);  // collecting again
        cyc("R5", 0, 0, 0, 0, 1, 0);                // strobe with latency 1
        idle("R4", 3, 1);

        // R7: restart discards a partial address; same-cycle events ignored
        cyc("R7", 1, 'h6666, 0, 0, 2, 0);
        cyc("R7", 0, 0, 1, 'hEEEE, 2, 1);
        cyc("R7", 0, 0, 1, 'hD0000007, 2, 0);
        idle("R7", 3, 2);
        cyc("R7", 1, 'h7070, 0, 0, 2, 0);
        idle("R7", 4, 2);

        // R8: restart mid-countdown
        cyc("R8", 1, 'h8888, 1, 'hD0000008, 9, 0);
        cyc("R8", 0, 0, 0, 0, 9, 0);
        idle("R8", 3, 9);
        cyc("R8", 0, 0, 0, 0, 9, 1);
        cyc("R8", 1, 'h8181, 1, 'hD0000081, 0, 0);
        idle("R8", 3, 0);

        // R9: restart in the strobe cycle
        cyc("R9", 1, 'h9090, 1, 'hD0000009, 4, 0);
        cyc("R9", 0, 0, 0, 0, 4, 1);
        idle("R9", 3, 4);
        cyc("R9", 0, 0, 1, 'hD0000091, 0, 0);
        cyc("R9", 1, 'h9191, 0, 0, 0, 0);
        idle("R9", 3, 0);

        check("R2", "strobe count", d_strobes, m_strobes);
        summary();
    end
endmodule